// File: doc/BRIEF.md
# Framed 24-bit serial command receiver

This block takes command words from a three-wire serial link: an active-low frame strobe, a serial clock and a data line. All three are sampled by a faster system clock. A frame opens when the strobe falls. Data is shifted in most significant bit first, one bit on each falling edge of the serial clock. When the 24th bit arrives, the block splits the word into a 3-bit command, a 3-bit address and a 16-bit data field. It then raises a one-cycle valid pulse.

If the strobe rises before the 24th bit, the partial word is dropped and a one-cycle abort pulse is raised instead. The data field is left-justified. A resolution parameter forces the unused low bits to zero, so a narrower converter core can use the top bits directly. What a command means, where values are stored and any readback path belong to the logic downstream of this block.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset the field outputs `cmd_o`, `addr_o` and `data_o` are zero, and `frame_valid_o` and `frame_abort_o` are low.
- R2: While `sync_ni` is low, one bit of `din_i` is captured on each falling edge of `sclk_i`, most significant bit first. The 24th falling edge completes the frame, and `frame_valid_o` is then high for exactly one system clock.
- R3: In the received word (bit 23 arrives first), bits 21:19 appear on `cmd_o` and bits 18:16 on `addr_o`. Bits 23:22 have no effect on any output.
- R4: `data_o` carries word bits 15:0 with the low `16-RES_BITS` bits forced to zero. With the default `RES_BITS=12`, `data_o[3:0]` is always 0.
- R5: If `sync_ni` rises after the frame has opened but before the 24th falling edge, `frame_abort_o` pulses for one cycle. In that case there is no `frame_valid_o` pulse and the field outputs do not change.
- R6: An aborted frame leaves no bits behind. The next complete frame decodes only its own 24 bits.
- R7: After a completed frame, a rise of `sync_ni` causes no abort pulse and no output change.
- R8: Falling edges of `sclk_i` after the 24th one, with `sync_ni` still low, are ignored. A new frame needs a fresh falling edge of `sync_ni`.
- R9: The field outputs stay stable in every cycle in which `frame_valid_o` is low.
- R10: `sclk_i` activity while `sync_ni` is high produces no pulse and no output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is captured on its falling edge |
| sync_ni | input | 1 | Active-low frame strobe |
| din_i | input | 1 | Serial data, MSB first |
| cmd_o | output | 3 | Command field of the last accepted frame |
| addr_o | output | 3 | Address field of the last accepted frame |
| data_o | output | 16 | Left-justified data field, low bits masked to the resolution |
| frame_valid_o | output | 1 | One-cycle pulse when a frame is accepted |
| frame_abort_o | output | 1 | One-cycle pulse when a frame is cut short |

## Verification
The embedded properties check, on every cycle, the following:
- both pulses last one cycle and never coincide;
- the field outputs hold whenever no valid pulse is present;
- the bit counter stays below 24;
- a high strobe leaves the shift core idle.

Only the bench scenarios can show the rest:
- bit ordering and field placement;
- the resolution mask;
- the absence of leftover bits after an abort;
- the silence on extra serial clocks once the strobe is held low past the 24th edge.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
  localparam int FRAME_BITS = 24;
  localparam int CMD_W      = 3;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 16;
  localparam int CMD_LSB    = 19;
  localparam int ADDR_LSB   = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_frame_t;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/scr_edge.sv
module scr_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/scr_shift_core.sv
module scr_shift_core
  import serial_cmd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sync_s_i,
  input  logic                  sync_fall_i,
  input  logic                  sync_rise_i,
  input  logic                  sclk_fall_i,
  input  logic                  din_s_i,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  accept_o,
  output logic                  abort_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic                  active_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] sreg_q;
  logic                  shift_en;

  assign shift_en = active_q & ~sync_s_i & ~sync_fall_i & sclk_fall_i;
  assign word_o   = {sreg_q[FRAME_BITS-2:0], din_s_i};
  assign accept_o = shift_en & (cnt_q == LAST_IDX);
  assign abort_o  = sync_rise_i & active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sreg_q   <= '0;
    end else if (sync_s_i) begin
      // strobe high: idle and cleared, partial bits dropped
      active_q <= 1'b0;
      cnt_q    <= '0;
      sreg_q   <= '0;
    end else if (sync_fall_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      sreg_q   <= '0;
    end else if (shift_en) begin
      sreg_q <= word_o;
      if (cnt_q == LAST_IDX) begin
        active_q <= 1'b0; // later edges ignored until strobe cycles
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(FRAME_BITS));
  p_idle_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_s_i |=> !active_q);
  p_accept_abort_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && abort_o));
  p_done_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !active_q);
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sync_ni,
  input  logic              din_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_valid_o,
  output logic              frame_abort_o
);
  localparam int                LOW_BITS  = DATA_W - RES_BITS;
  localparam logic [DATA_W-1:0] DATA_MASK = ~((DATA_W'(1) << LOW_BITS) - DATA_W'(1));

  logic [2:0]            raw_s;
  logic                  sclk_s, sync_s, din_s;
  logic                  sclk_rise_unused, sclk_fall;
  logic                  sync_rise, sync_fall;
  logic [FRAME_BITS-1:0] word;
  logic                  accept, abort;
  cmd_frame_t            frame_q;
  logic                  valid_q, abort_q;

  scr_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sync_ni, din_i}),
    .q_o   (raw_s)
  );
  assign {sclk_s, sync_s, din_s} = raw_s;

  scr_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sclk_s),
    .rise_o(sclk_rise_unused),
    .fall_o(sclk_fall)
  );

  scr_edge #(.RST_VAL(1'b1)) u_sync_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sync_s),
    .rise_o(sync_rise),
    .fall_o(sync_fall)
  );

  scr_shift_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_s_i   (sync_s),
    .sync_fall_i(sync_fall),
    .sync_rise_i(sync_rise),
    .sclk_fall_i(sclk_fall),
    .din_s_i    (din_s),
    .word_o     (word),
    .accept_o   (accept),
    .abort_o    (abort)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      valid_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      valid_q <= accept;
      abort_q <= abort;
      if (accept) begin
        frame_q.cmd  <= word[CMD_LSB +: CMD_W];
        frame_q.addr <= word[ADDR_LSB +: ADDR_W];
        frame_q.data <= word[DATA_W-1:0] & DATA_MASK;
      end
    end
  end

  assign cmd_o         = frame_q.cmd;
  assign addr_o        = frame_q.addr;
  assign data_o        = frame_q.data;
  assign frame_valid_o = valid_q;
  assign frame_abort_o = abort_q;

  p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);
  p_abort_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_abort_o |=> !frame_abort_o);
  p_abort_no_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_abort_o |-> !frame_valid_o);
  p_hold_fields_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_o |-> $stable({cmd_o, addr_o, data_o}));
endmodule

// File: tb/tb_serial_cmd_rx.sv
`timescale 1ns/1ps
module tb_serial_cmd_rx;
  localparam int RES = 12;
  localparam logic [15:0] MASK = 16'hFFFF << (16 - RES);
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    24'h000000, 24'hFFFFFF, 24'h800001, 24'h2ABCDE, 24'hD51234, 24'h1F8F0F
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sync_n = 1'b1, din = 1'b0;
  logic [2:0] cmd, addr;
  logic [15:0] data;
  logic valid, abort_p;
  int total = 0, bad = 0, vcnt = 0, acnt = 0, cycles = 0;

  always #2 clk = ~clk;

  serial_cmd_rx #(.RES_BITS(RES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sync_ni(sync_n), .din_i(din),
    .cmd_o(cmd), .addr_o(addr), .data_o(data),
    .frame_valid_o(valid), .frame_abort_o(abort_p)
  );

  always @(negedge clk) begin
    if (valid) vcnt++;
    if (abort_p) acnt++;
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clk_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); din = w[23-i]; sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic frame(input logic [23:0] w, input int n, input bit keep_low);
    @(negedge clk); sync_n = 1'b0;
    repeat (6) @(negedge clk);
    clk_bits(w, n);
    repeat (8) @(negedge clk);
    if (!keep_low) begin
      sync_n = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic check_fields(input string req, input logic [23:0] w);
    check({req, " cmd"}, 32'(cmd), 32'(w[21:19]));
    check({req, " addr"}, 32'(addr), 32'(w[18:16]));
    check({req, " data"}, 32'(data), 32'(w[15:0] & MASK));
  endtask

  initial begin
    int v0, a0;
    logic [21:0] snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 fields", {10'd0, cmd, addr, data}, 32'd0);
    check("R1 pulses", {30'd0, valid, abort_p}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: R2 ordering, R3 placement, R4 mask
    for (int k = 0; k < NV; k++) begin
      v0 = vcnt;
      frame(VEC[k], 24, 1'b0);
      check("R2 one valid", 32'(vcnt - v0), 32'd1);
      check_fields("R3/R4", VEC[k]);
    end
    check("R4 low bits zero", 32'(data[3:0]), 32'd0);

    // R5 abort after 10 bits
    snap = {cmd, addr, data};
    v0 = vcnt; a0 = acnt;
    frame(24'h3FFFFF, 10, 1'b0);
    check("R5 no valid", 32'(vcnt - v0), 32'd0);
    check("R5 abort pulse", 32'(acnt - a0), 32'd1);
    check("R5 fields held", 32'({cmd, addr, data}), 32'(snap));

    // R6 next frame clean after abort
    v0 = vcnt;
    frame(24'h0A5A5A, 24, 1'b0);
    check("R6 valid", 32'(vcnt - v0), 32'd1);
    check_fields("R6", 24'h0A5A5A);

    // R7/R8 strobe held low, extra clocks ignored
    v0 = vcnt; a0 = acnt;
    frame(24'h1C3210, 24, 1'b1);
    check("R8 first valid", 32'(vcnt - v0), 32'd1);
    clk_bits(24'h3FFFFF, 24);
    repeat (8) @(negedge clk);
    check("R8 no second valid", 32'(vcnt - v0), 32'd1);
    check_fields("R8", 24'h1C3210);
    sync_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R7 no abort on late rise", 32'(acnt - a0), 32'd0);
    check_fields("R7", 24'h1C3210);

    // R10 clocks with strobe high
    v0 = vcnt; a0 = acnt;
    clk_bits(24'hFFFFFF, 24);
    repeat (8) @(negedge clk);
    check("R10 no valid", 32'(vcnt - v0), 32'd0);
    check("R10 no abort", 32'(acnt - a0), 32'd0);
    check_fields("R10/R9", 24'h1C3210);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule